// File: doc/BRIEF.md
# Deferred Operation Stack Unit

This block holds the accumulator of a single-accumulator controller and the hardware last-in-first-out store that lets that accumulator evaluate bracketed expressions. An opening instruction names the operation that is to wait (for example "add" or "AND NOT"). The unit saves the accumulator, that operation and the current data type together as one stack entry. In the same clock cycle it loads the accumulator with the instruction's operand, so that the inner expression starts from a fresh value. A closing instruction takes the newest entry off the stack. It combines the saved value (left operand) with the accumulator (right operand) using the saved operation, and it restores the saved data type.

The newest entry always sits in a top-of-stack register. Older entries live in a storage array with a synchronous read. After a close that leaves entries behind, the register needs one cycle to refill from the array. A close that arrives in that cycle is held off with a stall and runs in the following cycle. Opens and loads never wait. A push onto a full stack or a pop from an empty one does nothing except set a sticky error flag.

Top module: `paren_stack_unit`

## Requirements
- R1: After a synchronous active-low reset, the accumulator reads 0, the type reads 3 (32-bit), stall and the error flag are low, and the stack is empty.
- R2: A load instruction (kind 0) copies the operand into the accumulator and the type input into the type register. Both show at the outputs after the next clock edge.
- R3: An open instruction (kind 1) pushes the accumulator, the op code and the current type as one entry. In the same edge it loads the operand and the type input, as a load does.
- R4: A close instruction (kind 2) pops the newest entry. It sets the accumulator to saved OP current and the type to the saved type.
- R5: Op codes: 0 AND, 1 saved AND NOT current, 2 OR, 3 saved OR NOT current, 4 XOR, 5 saved XOR NOT current, 6 add, 7 subtract (saved minus current). Codes 8 to 15 leave the current accumulator as the result.
- R6: Type codes: 0 is 1-bit, 1 is 8-bit, 2 is 16-bit, and 3 to 15 are 32-bit. The result of op codes 0 to 7 keeps only the bits of the saved type and zero-fills the rest, so a 1-bit result is bit 0 alone.
- R7: Entries come back in reverse order of pushing, up to 128 nested opens.
- R8: A close in the cycle right after an executed close that left the stack non-empty raises stall for that one cycle. That close does not execute, and it runs in the next cycle if it is held. Closes with any other cycle between them never stall.
- R9: An open in the cycle right after a close runs without a stall and keeps the stack order intact.
- R10: An open when 128 entries are stored sets the error flag and changes neither the stack, the accumulator nor the type.
- R11: A close on an empty stack sets the error flag and leaves the accumulator and the type unchanged.
- R12: The error flag stays set until reset.
- R13: Kind 3, or instr_vld low, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_vld | input | 1 | Instruction strobe |
| instr_kind | input | 2 | 0 load, 1 open, 2 close, 3 none |
| op_code | input | 4 | Deferred operation for an open |
| operand_in | input | 32 | New operand for load and open |
| type_in | input | 4 | Data type of the new operand |
| acc_out | output | 32 | Accumulator |
| type_out | output | 4 | Current data type |
| stall | output | 1 | Close held off this cycle |
| stack_err | output | 1 | Sticky overflow/underflow flag |

## Verification
Every op code is paired with every data type and with several bit patterns: all ones against one, alternating bits, and carry-heavy sums. This shows whether the width mask, the operand order of subtract and the inverted-operand variants are right. A 128-deep nest with mixed operations, unwound by back-to-back closes, separates correct stall timing and reverse ordering from stale top-of-stack reads. Closes spaced by an idle cycle, an open straight after a close, an overflow push and an empty pop each test one corner of the refill path and of the error flag.

// File: rtl/paren_pkg.sv
// Shared encodings for the deferred operation stack unit.
// Assumes 2-bit instruction kinds, 4-bit op codes and 4-bit type codes.
package paren_pkg;
    localparam logic [1:0] KIND_LOAD  = 2'd0;
    localparam logic [1:0] KIND_OPEN  = 2'd1;
    localparam logic [1:0] KIND_CLOSE = 2'd2;
    localparam logic [1:0] KIND_NONE  = 2'd3;

    localparam logic [3:0] OP_AND  = 4'd0;
    localparam logic [3:0] OP_ANDN = 4'd1;
    localparam logic [3:0] OP_OR   = 4'd2;
    localparam logic [3:0] OP_ORN  = 4'd3;
    localparam logic [3:0] OP_XOR  = 4'd4;
    localparam logic [3:0] OP_XORN = 4'd5;
    localparam logic [3:0] OP_ADD  = 4'd6;
    localparam logic [3:0] OP_SUB  = 4'd7;

    localparam logic [3:0] TY_BIT   = 4'd0;
    localparam logic [3:0] TY_BYTE  = 4'd1;
    localparam logic [3:0] TY_WORD  = 4'd2;
    localparam logic [3:0] TY_DWORD = 4'd3;
endpackage

// File: rtl/paren_alu.sv
// Combines a saved left operand with the current accumulator.
// Applies the saved operation and masks the result to the saved type.
// Assumes DATA_W >= 16. Unknown op codes pass the current value through.
module paren_alu #(
    parameter int DATA_W = 32,
    parameter int OP_W   = 4,
    parameter int TYPE_W = 4
) (
    input  logic [DATA_W-1:0] saved_val,
    input  logic [DATA_W-1:0] cur_val,
    input  logic [OP_W-1:0]   op,
    input  logic [TYPE_W-1:0] typ,
    output logic [DATA_W-1:0] result
);
    import paren_pkg::*;

    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] mask;
    logic              known;

    // Raw operation result, with the saved value as the left operand
    always_comb begin
        known = 1'b1;
        case (op)
            OP_AND:  raw = saved_val & cur_val;
            OP_ANDN: raw = saved_val & ~cur_val;
            OP_OR:   raw = saved_val | cur_val;
            OP_ORN:  raw = saved_val | ~cur_val;
            OP_XOR:  raw = saved_val ^ cur_val;
            OP_XORN: raw = saved_val ^ ~cur_val;
            OP_ADD:  raw = saved_val + cur_val;
            OP_SUB:  raw = saved_val - cur_val;
            default: begin
                raw   = cur_val;
                known = 1'b0;
            end
        endcase
    end

    // Width mask selected by the data type code
    always_comb begin
        case (typ)
            TY_BIT:  mask = DATA_W'(1);
            TY_BYTE: mask = DATA_W'(8'hFF);
            TY_WORD: mask = DATA_W'(16'hFFFF);
            default: mask = '1;
        endcase
    end

    // Final result: masked when the op is known, pass-through otherwise
    always_comb result = known ? (raw & mask) : cur_val;
endmodule

// File: rtl/paren_lifo.sv
// Hardware LIFO with a registered top entry and a synchronous-read array.
// The newest entry is held in tos_q and older entries in mem_q.
// After a pop that leaves entries behind, refill_q is high for one cycle
// while tos_q reloads from the array. The parent must not pop in that cycle.
// A push onto a full stack or a pop from an empty one only sets err_q.
module paren_lifo #(
    parameter int ENTRY_W = 40,
    parameter int DEPTH   = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_req,
    input  logic               pop_req,
    input  logic [ENTRY_W-1:0] push_data,
    output logic [ENTRY_W-1:0] tos,
    output logic               empty,
    output logic               full,
    output logic               refill,
    output logic               err
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0]      sp_q;
    logic [ENTRY_W-1:0] tos_q;
    logic [ENTRY_W-1:0] rd_q;
    logic               refill_q;
    logic               err_q;
    logic [ENTRY_W-1:0] mem_q [DEPTH];

    logic [AW-1:0] wr_idx;
    logic [AW-1:0] rd_idx;
    logic          wr_en;
    logic          push_ok;
    logic          pop_ok;

    assign empty  = (sp_q == '0);
    assign full   = (sp_q == PW'(DEPTH));
    assign tos    = tos_q;
    assign refill = refill_q;
    assign err    = err_q;

    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !push_req && !empty && !refill_q;
    assign wr_idx  = AW'(sp_q - PW'(1));
    assign rd_idx  = AW'(sp_q - PW'(2));
    // During a refill the old top is still in the array, so no spill.
    assign wr_en   = push_ok && !empty && !refill_q;

    // Spill the old top into the array when a new entry is pushed
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= tos_q;
    end

    // Synchronous read of the entry just below the top
    always_ff @(posedge clk) begin
        rd_q <= mem_q[rd_idx];
    end

    // Stack pointer, top register, refill and error tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q     <= '0;
            tos_q    <= '0;
            refill_q <= 1'b0;
            err_q    <= 1'b0;
        end else if (push_req) begin
            if (full) begin
                err_q <= 1'b1;
            end else begin
                sp_q     <= sp_q + PW'(1);
                tos_q    <= push_data;
                refill_q <= 1'b0;
            end
        end else if (pop_req && empty) begin
            err_q <= 1'b1;
        end else if (pop_ok) begin
            sp_q     <= sp_q - PW'(1);
            refill_q <= (sp_q > PW'(1));
        end else if (refill_q) begin
            tos_q    <= rd_q;
            refill_q <= 1'b0;
        end
    end

    // R10
    sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= PW'(DEPTH));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> ($stable(sp_q) && err_q));

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R8
    refill_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_q |=> !refill_q);

    // R7
    push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> (sp_q == $past(sp_q) + PW'(1)));
endmodule

// File: rtl/paren_stack_unit.sv
// Accumulator with deferred-operation stack for bracketed expressions.
// Open pushes {acc, op, type} and loads the operand. Close pops and
// applies saved OP acc. A close right after a close that left entries
// stalls for one cycle. Assumes the source holds a stalled close.
module paren_stack_unit #(
    parameter int DATA_W = 32,
    parameter int OP_W   = 4,
    parameter int TYPE_W = 4,
    parameter int DEPTH  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_vld,
    input  logic [1:0]        instr_kind,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] operand_in,
    input  logic [TYPE_W-1:0] type_in,
    output logic [DATA_W-1:0] acc_out,
    output logic [TYPE_W-1:0] type_out,
    output logic              stall,
    output logic              stack_err
);
    import paren_pkg::*;

    localparam int ENTRY_W = DATA_W + OP_W + TYPE_W;

    logic [DATA_W-1:0]  acc_q;
    logic [TYPE_W-1:0]  type_q;
    logic               is_load, is_open, is_close;
    logic               pop_go;
    logic [ENTRY_W-1:0] tos;
    logic               st_empty, st_full, st_refill;
    logic [DATA_W-1:0]  sv_acc;
    logic [OP_W-1:0]    sv_op;
    logic [TYPE_W-1:0]  sv_type;
    logic [DATA_W-1:0]  alu_res;

    // Instruction decode
    always_comb begin
        is_load  = instr_vld && (instr_kind == KIND_LOAD);
        is_open  = instr_vld && (instr_kind == KIND_OPEN);
        is_close = instr_vld && (instr_kind == KIND_CLOSE);
    end

    assign stall  = is_close && st_refill;
    assign pop_go = is_close && !st_refill && !st_empty;
    assign {sv_acc, sv_op, sv_type} = tos;

    paren_lifo #(
        .ENTRY_W (ENTRY_W),
        .DEPTH   (DEPTH)
    ) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (is_open),
        .pop_req   (is_close && !st_refill),
        .push_data ({acc_q, op_code, type_q}),
        .tos       (tos),
        .empty     (st_empty),
        .full      (st_full),
        .refill    (st_refill),
        .err       (stack_err)
    );

    paren_alu #(
        .DATA_W (DATA_W),
        .OP_W   (OP_W),
        .TYPE_W (TYPE_W)
    ) u_alu (
        .saved_val (sv_acc),
        .cur_val   (acc_q),
        .op        (sv_op),
        .typ       (sv_type),
        .result    (alu_res)
    );

    // Accumulator and type register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            type_q <= TYPE_W'(TY_DWORD);
        end else if (is_load || (is_open && !st_full)) begin
            acc_q  <= operand_in;
            type_q <= type_in;
        end else if (pop_go) begin
            acc_q  <= alu_res;
            type_q <= sv_type;
        end
    end

    assign acc_out  = acc_q;
    assign type_out = type_q;

    // R8
    stall_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> $past(pop_go));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(acc_q) && $stable(type_q)));

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_close && st_empty) |=> ($stable(acc_q) && stack_err));
endmodule

// File: tb/paren_stack_unit_test.sv
`timescale 1ns/1ps
module paren_stack_unit_test;
    localparam int DEPTH = 128;
    localparam logic [1:0] K_LOAD = 2'd0, K_OPEN = 2'd1, K_CLOSE = 2'd2, K_NONE = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_vld = 1'b0;
    logic [1:0]  instr_kind = K_NONE;
    logic [3:0]  op_code = '0;
    logic [31:0] operand_in = '0;
    logic [3:0]  type_in = '0;
    logic [31:0] acc_out;
    logic [3:0]  type_out;
    logic        stall;
    logic        stack_err;

    int n_chk = 0;
    int n_bad = 0;

    // reference model
    logic [31:0] m_val [DEPTH];
    logic [3:0]  m_op  [DEPTH];
    logic [3:0]  m_ty  [DEPTH];
    int          m_n = 0;
    logic [31:0] m_acc = '0;
    logic [3:0]  m_type = 4'd3;
    logic        m_err = 1'b0;
    logic        m_prev_pop = 1'b0;

    always #5 clk = ~clk;

    paren_stack_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr_kind(instr_kind),
        .op_code(op_code), .operand_in(operand_in), .type_in(type_in),
        .acc_out(acc_out), .type_out(type_out), .stall(stall), .stack_err(stack_err)
    );

    function automatic logic [31:0] ref_op(input logic [31:0] s, input logic [31:0] c,
                                           input logic [3:0] op, input logic [3:0] ty);
        logic [31:0] r;
        logic [31:0] m;
        if (op > 4'd7) return c;
        case (op)
            4'd0: r = s & c;
            4'd1: r = s & ~c;
            4'd2: r = s | c;
            4'd3: r = s | ~c;
            4'd4: r = s ^ c;
            4'd5: r = ~(s ^ c);
            4'd6: r = s + c;
            default: r = s + (~c + 32'd1);
        endcase
        if (ty == 4'd0) m = 32'd1;
        else if (ty == 4'd1) m = 32'd255;
        else if (ty == 4'd2) m = 32'd65535;
        else m = 32'hFFFF_FFFF;
        return r & m;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        check(tag, "acc", acc_out, m_acc);
        check(tag, "type", {28'd0, type_out}, {28'd0, m_type});
        check(tag, "err", {31'd0, stack_err}, {31'd0, m_err});
    endtask

    // one instruction, repeated while stalled; consecutive calls are back-to-back cycles
    task automatic run(input logic [1:0] kind, input logic [3:0] op, input logic [31:0] val,
                       input logic [3:0] ty, input string tag);
        logic exp_stall;
        logic done;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            instr_vld = 1'b1; instr_kind = kind; op_code = op; operand_in = val; type_in = ty;
            #1;
            exp_stall = (kind == K_CLOSE) && m_prev_pop;
            check(tag, "stall", {31'd0, stall}, {31'd0, exp_stall});
            @(posedge clk);
            #1;
            if (exp_stall) begin
                m_prev_pop = 1'b0;
            end else begin
                done = 1'b1;
                m_prev_pop = 1'b0;
                if (kind == K_LOAD) begin
                    m_acc = val; m_type = ty;
                end else if (kind == K_OPEN) begin
                    if (m_n == DEPTH) m_err = 1'b1;
                    else begin
                        m_val[m_n] = m_acc; m_op[m_n] = op; m_ty[m_n] = m_type;
                        m_n++;
                        m_acc = val; m_type = ty;
                    end
                end else if (kind == K_CLOSE) begin
                    if (m_n == 0) m_err = 1'b1;
                    else begin
                        m_n--;
                        m_acc = ref_op(m_val[m_n], m_acc, m_op[m_n], m_ty[m_n]);
                        m_type = m_ty[m_n];
                        m_prev_pop = (m_n > 0);
                    end
                end
                check_outs(tag);
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        instr_vld = 1'b0; instr_kind = K_NONE;
        @(posedge clk);
        #1;
        m_prev_pop = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; instr_vld = 1'b0; instr_kind = K_NONE;
        @(posedge clk); @(posedge clk);
        #1;
        m_n = 0; m_acc = '0; m_type = 4'd3; m_err = 1'b0; m_prev_pop = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", "acc", acc_out, 32'd0);
        check("R1", "type", {28'd0, type_out}, 32'd3);
        check("R1", "stall", {31'd0, stall}, 32'd0);
        check("R1", "err", {31'd0, stack_err}, 32'd0);

        // R2 R3 R4 R5 R6: every op x type x pattern
        for (int op = 0; op < 8; op++) begin
            for (int ty = 0; ty < 4; ty++) begin
                for (int p = 0; p < 4; p++) begin
                    logic [31:0] a;
                    logic [31:0] b;
                    case (p)
                        0: begin a = 32'hFFFF_FFFF; b = 32'h0000_0001; end
                        1: begin a = 32'hAAAA_5555; b = 32'h5A5A_F00F; end
                        2: begin a = 32'h0000_00FF; b = 32'h0001_0101; end
                        default: begin a = 32'h9E37_79B9 * (op + 1); b = 32'h7F4A_7C15 ^ (ty * 32'h0101_0101); end
                    endcase
                    run(K_LOAD, 4'd0, a, 4'(ty), "R2");
                    run(K_OPEN, 4'(op), b, 4'd3, "R3");
                    run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R5_R6_R4");
                end
            end
        end

        // R5 unknown op code passes current accumulator
        run(K_LOAD, 4'd0, 32'h1234_5678, 4'd0, "R2");
        run(K_OPEN, 4'd12, 32'hCAFE_0001, 4'd3, "R3");
        run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R5");

        // R13 ignored instruction
        run(K_NONE, 4'd2, 32'hDEAD_BEEF, 4'd1, "R13");
        @(negedge clk);
        instr_vld = 1'b0; instr_kind = K_LOAD; operand_in = 32'h0BAD_0BAD;
        @(posedge clk); #1;
        m_prev_pop = 1'b0;
        check_outs("R13");

        // R7 R10: full-depth nest, overflow push, then back-to-back unwind (R8)
        run(K_LOAD, 4'd0, 32'd1, 4'd3, "R2");
        for (int i = 0; i < DEPTH; i++)
            run(K_OPEN, 4'(i % 8), 32'(i * 3 + 5), 4'(i % 4), "R7");
        run(K_OPEN, 4'd6, 32'h7777_7777, 4'd1, "R10");
        for (int i = 0; i < DEPTH; i++)
            run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R7_R8");

        // R12 error survives later work
        run(K_LOAD, 4'd0, 32'h55, 4'd3, "R12");

        // R11 pop on empty
        do_reset();
        run(K_LOAD, 4'd0, 32'h0000_ABCD, 4'd2, "R2");
        run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R11");
        run(K_LOAD, 4'd0, 32'h1, 4'd3, "R12");

        // R8 spaced closes do not stall
        do_reset();
        run(K_LOAD, 4'd0, 32'd10, 4'd3, "R2");
        run(K_OPEN, 4'd6, 32'd20, 4'd3, "R3");
        run(K_OPEN, 4'd7, 32'd30, 4'd3, "R3");
        run(K_OPEN, 4'd2, 32'd40, 4'd3, "R3");
        run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R8");
        idle();
        run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R8");
        idle();
        run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R8");

        // R9 open right after close, then unwind
        run(K_LOAD, 4'd0, 32'h100, 4'd3, "R2");
        run(K_OPEN, 4'd6, 32'h200, 4'd3, "R3");
        run(K_OPEN, 4'd7, 32'h300, 4'd2, "R3");
        run(K_OPEN, 4'd4, 32'h0F0F, 4'd1, "R3");
        run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R9");
        run(K_OPEN, 4'd1, 32'h00FF, 4'd3, "R9");
        run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R9");
        run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R9");
        run(K_CLOSE, 4'd0, 32'd0, 4'd0, "R9");
        idle();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule